// File: doc/BRIEF.md
# Multiprocessor-Format Serial Transmitter

This block sends asynchronous serial frames in which an extra flag bit follows the data bits. A receiver uses that bit to tell address frames from data frames. Each frame is made of a low start bit, then 7 or 8 data bits with the least significant bit first, then the flag bit, then one or two high stop bits. Between frames the line rests high. Every bit lasts one period of a baud tick that comes from outside the block.

The host writes bytes into a one-entry holding register through a valid/ready port. `wr_ready` is high exactly when the holding register is empty. A byte is taken on a clock edge where both `wr_valid` and `wr_ready` are high. The host may keep `wr_valid` high for as long as it likes while `wr_ready` is low, and nothing is taken during that time. The sequencer moves the held byte into its shift register at a baud tick, which makes the holding register empty again. At the tick that ends the last stop bit, the sequencer looks at the holding register once more. If a byte is waiting, the next frame starts with no idle gap. If the register is empty, a transmit-end flag is raised and the line stays high.

Two level interrupt requests are produced, each one gated by its own enable: holding register empty, and transmission ended.

Top module: `mp_serial_tx`

## Requirements
- R1: When the holding register is full at a baud tick while the line is idle, the byte is moved into the shift register, and `txd` goes to 0 (the start bit) on the next clock.
- R2: The cycle after a byte moves into the shift register, `empty_flag` reads 1.
- R3: A frame is sent in this order: one 0 start bit, the data bits with the LSB first, the flag bit, and then 1-valued stop bits. When the block is reset, `txd` is 1, and it stays 1 whenever no frame is in progress.
- R4: The flag bit of a frame equals `mpb_value` as sampled when that frame's byte was loaded.
- R5: Each bit lasts exactly one baud-tick period, and `txd` changes only on the clock after a tick. `cfg_seven` (1 = 7 data bits, 0 = 8) and `cfg_two_stop` (1 = two stop bits, 0 = one) are sampled at load, so changing them in the middle of a frame does not affect that frame.
- R6: If a byte is waiting at the tick that ends the last stop bit, the next start bit follows immediately and `end_flag` stays 0.
- R7: If no byte is waiting at that tick, `end_flag` is set to 1 and `txd` stays 1.
- R8: `wr_ready` equals the empty state of the holding register. An accepted write clears both `empty_flag` and `end_flag`, and a write in the same cycle as an end event wins. After reset, both flags are 1.
- R9: `irq_empty` is `empty_flag` AND `ie_empty`, and `irq_end` is `end_flag` AND `ie_end`. Both are levels that stay up until their flag is cleared.
- R10: In 7-bit mode, bit 7 of the written byte is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse that marks each bit period |
| wr_valid | input | 1 | Host offers a byte |
| wr_ready | output | 1 | Holding register can accept a byte |
| wr_data | input | 8 | Byte to send |
| cfg_seven | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| mpb_value | input | 1 | Value of the flag bit for the next frame |
| ie_empty | input | 1 | Enable for the empty interrupt |
| ie_end | input | 1 | Enable for the transmit-end interrupt |
| txd | output | 1 | Serial line |
| empty_flag | output | 1 | Holding register is empty |
| end_flag | output | 1 | Transmission ended with nothing waiting |
| irq_empty | output | 1 | Empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
The assertions check on every cycle the local rules of the block:
- the start bit is low, and the stop and idle levels are high;
- the flag bit carries its latched value;
- `txd` changes only after a tick;
- a load happens only from a full holding register and leaves it empty;
- an accepted write clears both flags;
- the end flag rises only while the line is high.

Some properties can only be shown by the bench's reference model, which compares every output on every clock:
- the full bit order, the data values and the frame length;
- the 7-bit masking and the sampling of the settings at load;
- back-to-back frames with no gap, and the interaction between a write and an end event.

// File: rtl/mptx_pkg.sv
package mptx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_MPB,
    ST_STOP1,
    ST_STOP2
  } tx_state_e;

  typedef struct packed {
    logic seven;
    logic two_stop;
    logic mpb;
  } frame_cfg_t;
endpackage

// File: rtl/mptx_hold.sv
module mptx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  input  logic              end_set,
  input  logic              ie_empty,
  input  logic              ie_end,
  output logic [DATA_W-1:0] hold_data,
  output logic              empty_flag,
  output logic              end_flag,
  output logic              irq_empty,
  output logic              irq_end
);
  logic              empty_q;
  logic              end_q;
  logic [DATA_W-1:0] data_q;
  logic              fire;

  assign fire = wr_valid && empty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      end_q   <= 1'b1;
      data_q  <= '0;
    end else begin
      if (load) empty_q <= 1'b1;
      if (fire) begin
        data_q  <= wr_data;
        empty_q <= 1'b0;
        end_q   <= 1'b0;
      end else if (end_set) begin
        end_q <= 1'b1;
      end
    end
  end

  assign wr_ready   = empty_q;
  assign hold_data  = data_q;
  assign empty_flag = empty_q;
  assign end_flag   = end_q;
  assign irq_empty  = empty_q && ie_empty;
  assign irq_end    = end_q && ie_end;

  // R1: the sequencer only loads from a full holding register
  p_load_from_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !empty_q);
  // R2: a load leaves the holding register empty
  p_load_sets_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> empty_q);
endmodule

// File: rtl/mptx_shift.sv
module mptx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  output logic         lsb
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        sh_q <= '0;
    else if (load)     sh_q <= load_val;
    else if (shift_en) sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign lsb = sh_q[0];
endmodule

// File: rtl/mptx_frame.sv
module mptx_frame
  import mptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  frame_cfg_t        cfg,
  output logic              load,
  output logic              end_set,
  output logic              txd
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] NB_LONG  = CW'(DATA_W);
  localparam logic [CW-1:0] NB_SHORT = CW'(DATA_W - 1);
  localparam logic [DATA_W-1:0] SHORT_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  tx_state_e     state_q, state_n;
  frame_cfg_t    cfg_q;
  logic [CW-1:0] cnt_q, cnt_n, nbits_q;
  logic          txd_q, txd_n;
  logic          shift_en, lsb, frame_done;
  logic [DATA_W-1:0] load_val;

  assign load_val = cfg.seven ? (hold_data & SHORT_MASK) : hold_data;

  mptx_shift #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .shift_en (shift_en),
    .lsb      (lsb)
  );

  always_comb begin
    state_n    = state_q;
    txd_n      = txd_q;
    cnt_n      = cnt_q;
    load       = 1'b0;
    end_set    = 1'b0;
    shift_en   = 1'b0;
    frame_done = 1'b0;
    if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (hold_full) begin
            load    = 1'b1;
            state_n = ST_START;
            txd_n   = 1'b0;
          end
        end
        ST_START: begin
          state_n  = ST_DATA;
          txd_n    = lsb;
          shift_en = 1'b1;
          cnt_n    = CW'(1);
        end
        ST_DATA: begin
          if (cnt_q == nbits_q) begin
            state_n = ST_MPB;
            txd_n   = cfg_q.mpb;
          end else begin
            txd_n    = lsb;
            shift_en = 1'b1;
            cnt_n    = cnt_q + CW'(1);
          end
        end
        ST_MPB: begin
          state_n = ST_STOP1;
          txd_n   = 1'b1;
        end
        ST_STOP1: begin
          if (cfg_q.two_stop) begin
            state_n = ST_STOP2;
            txd_n   = 1'b1;
          end else begin
            frame_done = 1'b1;
          end
        end
        ST_STOP2: frame_done = 1'b1;
        default:  state_n = ST_IDLE;
      endcase
      if (frame_done) begin
        if (hold_full) begin
          load    = 1'b1;
          state_n = ST_START;
          txd_n   = 1'b0;
        end else begin
          end_set = 1'b1;
          state_n = ST_IDLE;
          txd_n   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      txd_q   <= 1'b1;
      cnt_q   <= '0;
      nbits_q <= NB_LONG;
      cfg_q   <= '0;
    end else begin
      state_q <= state_n;
      txd_q   <= txd_n;
      cnt_q   <= cnt_n;
      if (load) begin
        cfg_q   <= cfg;
        nbits_q <= cfg.seven ? NB_SHORT : NB_LONG;
      end
    end
  end

  assign txd = txd_q;

  // R3: start bit is low
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START) |-> !txd_q);
  // R3: stop bits and idle are high
  p_mark_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP1 || state_q == ST_STOP2 || state_q == ST_IDLE) |-> txd_q);
  // R4: flag bit carries the latched value
  p_mpb_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MPB) |-> (txd_q == cfg_q.mpb));
  // R5: the line moves only after a baud tick
  p_txd_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd_q) |-> $past(tick));
endmodule

// File: rtl/mp_serial_tx.sv
module mp_serial_tx
  import mptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cfg_seven,
  input  logic              cfg_two_stop,
  input  logic              mpb_value,
  input  logic              ie_empty,
  input  logic              ie_end,
  output logic              txd,
  output logic              empty_flag,
  output logic              end_flag,
  output logic              irq_empty,
  output logic              irq_end
);
  logic              load, end_set;
  logic [DATA_W-1:0] hold_data;
  frame_cfg_t        cfg;

  assign cfg = '{seven: cfg_seven, two_stop: cfg_two_stop, mpb: mpb_value};

  mptx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .load       (load),
    .end_set    (end_set),
    .ie_empty   (ie_empty),
    .ie_end     (ie_end),
    .hold_data  (hold_data),
    .empty_flag (empty_flag),
    .end_flag   (end_flag),
    .irq_empty  (irq_empty),
    .irq_end    (irq_end)
  );

  mptx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .hold_full (!empty_flag),
    .hold_data (hold_data),
    .cfg       (cfg),
    .load      (load),
    .end_set   (end_set),
    .txd       (txd)
  );

  // R8: an accepted write clears both flags
  p_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!empty_flag && !end_flag));
  // R7: the end flag rises only while the line is marking
  p_end_marking_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> txd);
  // R9: the end request never stands without its flag
  p_irq_end_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |-> end_flag);
endmodule

// File: tb/sim_mp_serial_tx.sv
module sim_mp_serial_tx;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic cfg_seven = 1'b0, cfg_two_stop = 1'b0, mpb_value = 1'b0;
  logic ie_empty = 1'b0, ie_end = 1'b0;
  logic wr_ready, txd, empty_flag, end_flag, irq_empty, irq_end;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int tick_cnt = 0;

  always #4 clk = ~clk;

  mp_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .cfg_seven(cfg_seven), .cfg_two_stop(cfg_two_stop), .mpb_value(mpb_value),
    .ie_empty(ie_empty), .ie_end(ie_end), .txd(txd),
    .empty_flag(empty_flag), .end_flag(end_flag),
    .irq_empty(irq_empty), .irq_end(irq_end)
  );

  // reference model state
  bit       m_empty = 1;
  bit       m_end = 1;
  bit [7:0] m_hold = '0;
  bit       bitq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // build one frame in the model (R3 order, R4 flag, R10 masking, R5 sampled config)
  task automatic m_build();
    int nb;
    nb = cfg_seven ? 7 : 8;
    bitq.push_back(1'b0);
    for (int i = 0; i < nb; i++) bitq.push_back(m_hold[i]);
    bitq.push_back(mpb_value);
    bitq.push_back(1'b1);
    if (cfg_two_stop) bitq.push_back(1'b1);
    m_empty = 1;
  endtask

  always @(posedge clk) begin
    bit old_empty;
    if (!rst_n) begin
      m_empty = 1; m_end = 1; m_hold = '0; bitq.delete();
    end else begin
      old_empty = m_empty;
      if (baud_tick) begin
        if (bitq.size() > 0) begin
          void'(bitq.pop_front());
          if (bitq.size() == 0) begin
            if (!old_empty) m_build();   // R6 back-to-back
            else m_end = 1;              // R7 end of transmission
          end
        end else if (!old_empty) begin
          m_build();                     // R1 load from idle
        end
      end
      if (wr_valid && old_empty) begin   // R8 write wins over an end event
        m_hold = wr_data; m_empty = 0; m_end = 0;
      end
    end
  end

  always @(negedge clk) begin
    bit exp_txd;
    if (rst_n) begin
      exp_txd = (bitq.size() > 0) ? bitq[0] : 1'b1;
      chk(txd == exp_txd, "R3/R5/R6 txd", txd, exp_txd);
      chk(empty_flag == m_empty, "R2 empty_flag", empty_flag, m_empty);
      chk(wr_ready == m_empty, "R8 wr_ready", wr_ready, m_empty);
      chk(end_flag == m_end, "R7 end_flag", end_flag, m_end);
      chk(irq_empty == (m_empty && ie_empty), "R9 irq_empty", irq_empty, m_empty && ie_empty);
      chk(irq_end == (m_end && ie_end), "R9 irq_end", irq_end, m_end && ie_end);
    end
    tick_cnt = (tick_cnt + 1) % TICK_DIV;
    baud_tick = (tick_cnt == 0);
  end

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    @(negedge clk);
    while (!end_flag && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at %0t: actual=0 expected=1", $time);
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8: reset state of both flags and the line
    chk(txd == 1'b1, "R8 reset txd", txd, 1);
    chk(empty_flag == 1'b1, "R8 reset empty", empty_flag, 1);
    chk(end_flag == 1'b1, "R8 reset end", end_flag, 1);
    chk(wr_ready == 1'b1, "R8 reset ready", wr_ready, 1);

    // R1 R3 R4: 8 data bits, one stop bit, flag bit set
    ie_empty = 1; ie_end = 1; mpb_value = 1;
    send(8'hA5);
    wait_end();
    chk(end_flag == 1'b1, "R7 end after single frame", end_flag, 1);

    // R10 R5: 7-bit mode with bit 7 set, two stops; settings change mid-frame
    cfg_seven = 1; cfg_two_stop = 1; mpb_value = 0;
    send(8'hC3);
    repeat (12) @(negedge clk);
    cfg_seven = 0; cfg_two_stop = 0; mpb_value = 1;
    wait_end();

    // R6: back-to-back frames with no gap; R9 enables toggled
    cfg_seven = 0; cfg_two_stop = 0; ie_end = 0;
    send(8'h3C);
    send(8'hFF);
    ie_empty = 0;
    send(8'h01);
    ie_empty = 1; ie_end = 1;
    wait_end();

    // mixed settings and gaps, including writes near end events
    for (int i = 0; i < 40; i++) begin
      cfg_seven = i[0];
      cfg_two_stop = i[1];
      mpb_value = i[2];
      ie_empty = i[3];
      ie_end = ~i[0];
      send(8'($urandom));
      repeat ($urandom_range(0, 60)) @(negedge clk);
    end
    wait_end();
    repeat (10) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule